// File: doc/BRIEF.md
# Prescaled Reloading Wake-up Timer

This block is a free-running system timer that keeps time across low-power states. A prescaler divides a selectable tick, either every core clock or a crystal-oscillator enable pulse, and each time the prescaler expires it steps a loadable down counter. Together the two stages form one counting chain. With the default parameters this chain is 7 + 16 = 23 bits.

When the down counter is stepped while it already holds zero, it reloads the programmed value and raises a sticky event flag. The flag is presented on an interrupt output and on a wake-up output, and each output has its own enable. Software controls the timer through a small byte-wide register port using plain write and read strobes. Writes take effect on the clock edge. Read data is combinational from the address. The live count is read as a low byte then a high byte, and the read of the low byte captures the upper bits so that the two halves belong together.

Only the power-on reset and the watchdog reset clear the timer. Any other reset in the system leaves it untouched, so it keeps counting through a core reset.

Top module: `wake_timer`

## Requirements
- R1: While running, the counter steps once for every 2^PRESC_W selected ticks. After a preload, the first step comes only after a full 2^PRESC_W ticks.
- R2: A step decrements the count by one. A step taken while the count is zero loads the reload value instead and sets the flag. The flag therefore first appears (reload+1)·2^PRESC_W ticks after the run starts.
- R3: CTRL (address 0) bit 1 picks the tick source. With 0, every core clock is a tick. With 1, only cycles with `osc_tick` high are ticks.
- R4: With CTRL bit 0 (run) clear, the count and the prescaler hold their values.
- R5: The reload value is written as a low byte (address 2) and upper bits (address 3). A write while run is clear also loads the count with the new reload value and restarts the prescaler. A write while running changes only the reload value, which takes effect at the next wrap.
- R6: The flag reads as STAT (address 1) bit 0 and stays set until a write to STAT with bit 0 set. A write with bit 0 clear has no effect. If a wrap and a clear fall in the same cycle, the wrap wins.
- R7: `irq` is high when the flag is set and CTRL bit 2 is set. `wake` is high when the flag is set and CTRL bit 3 is set.
- R8: Address 4 returns the low count byte. A read strobe at address 4 captures the upper count bits, which address 5 returns unchanged until the next strobed read of address 4.
- R9: Either `por_rst_n` or `wdt_rst_n` low returns the timer to its defaults: CTRL 0, reload 0, count 0, flag 0, and prescaler full.
- R10: Addresses 0, 2 and 3 read back their written values zero-extended to 8 bits. Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_rst_n | input | 1 | Power-on reset, active low, asynchronous |
| wdt_rst_n | input | 1 | Watchdog reset, active low, asynchronous |
| osc_tick | input | 1 | One-cycle enable per oscillator period |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect at address 4 only) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq | output | 1 | Interrupt request (flag and interrupt enable) |
| wake | output | 1 | Wake-up request (flag and wake enable) |

## Verification
The bench builds the timer with a 2-bit prescaler and a 10-bit counter. With this configuration, a full period is only 4·(reload+1) ticks. The time to the flag can therefore be walked cycle by cycle for a sweep of reload values, from zero up to a value that needs the upper bits, under both tick sources.

The 10-bit counter leaves only two upper bits. This lets the live count be sampled across several wraps, with the expected value computed from elapsed ticks. It also lets the upper-bit capture be seen going stale while the count crosses a 256 boundary.

// File: rtl/wkt_pkg.sv
package wkt_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned REG_ADDR_W = 3;

  localparam logic [REG_ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [REG_ADDR_W-1:0] A_STAT = 3'd1;
  localparam logic [REG_ADDR_W-1:0] A_RLO  = 3'd2;
  localparam logic [REG_ADDR_W-1:0] A_RHI  = 3'd3;
  localparam logic [REG_ADDR_W-1:0] A_CLO  = 3'd4;
  localparam logic [REG_ADDR_W-1:0] A_CHI  = 3'd5;

  typedef struct packed {
    logic wake_en;
    logic irq_en;
    logic src_osc;
    logic run;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/wkt_tick_sel.sv
module wkt_tick_sel (
  input  logic run,
  input  logic src_osc,
  input  logic osc_tick,
  output logic tick
);
  always_comb begin
    if (!run)         tick = 1'b0;
    else if (src_osc) tick = osc_tick;
    else              tick = 1'b1;
  end
endmodule

// File: rtl/wkt_prescaler.sv
module wkt_prescaler #(
  parameter int unsigned PRESC_W = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  output logic step
);
  logic [PRESC_W-1:0] presc_q;

  assign step = tick && (presc_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     presc_q <= '1;
    else if (clear) presc_q <= '1;
    else if (tick)  presc_q <= presc_q - 1'b1;
  end
endmodule

// File: rtl/wkt_counter.sv
module wkt_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             preload,
  input  logic [CNT_W-1:0] preload_val,
  input  logic             step,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_q;

  assign count = cnt_q;
  assign wrap  = step && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (preload) cnt_q <= preload_val;
    else if (wrap)    cnt_q <= reload;
    else if (step)    cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/wkt_regs.sv
module wkt_regs
  import wkt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0]     bus_wdata,
  output logic [BYTE_W-1:0]     bus_rdata,
  input  logic [CNT_W-1:0]      count,
  input  logic                  wrap,
  output ctrl_t                 ctrl,
  output logic [CNT_W-1:0]      reload,
  output logic                  preload,
  output logic [CNT_W-1:0]      preload_val,
  output logic                  flag,
  output logic                  flag_clr,
  output logic                  lat_en,
  output logic [CNT_W-BYTE_W-1:0] hi_latch
);
  localparam int unsigned HI_W = CNT_W - BYTE_W;

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] reload_q, reload_nxt;
  logic             flag_q;
  logic [HI_W-1:0]  hi_q;
  logic             wr_ctrl, wr_stat, wr_rlo, wr_rhi;

  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_stat = bus_wr && (bus_addr == A_STAT);
  assign wr_rlo  = bus_wr && (bus_addr == A_RLO);
  assign wr_rhi  = bus_wr && (bus_addr == A_RHI);
  assign lat_en  = bus_rd && (bus_addr == A_CLO);

  always_comb begin
    reload_nxt = reload_q;
    if (wr_rlo) reload_nxt[BYTE_W-1:0]     = bus_wdata;
    if (wr_rhi) reload_nxt[CNT_W-1:BYTE_W] = bus_wdata[HI_W-1:0];
  end

  assign preload     = (wr_rlo || wr_rhi) && !ctrl_q.run;
  assign preload_val = reload_nxt;
  assign flag_clr    = wr_stat && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      flag_q   <= 1'b0;
      hi_q     <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
      reload_q <= reload_nxt;
      if (wrap)          flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
      if (lat_en) hi_q <= count[CNT_W-1:BYTE_W];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: bus_rdata[CTRL_W-1:0] = ctrl_q;
      A_STAT: bus_rdata[0]          = flag_q;
      A_RLO:  bus_rdata             = reload_q[BYTE_W-1:0];
      A_RHI:  bus_rdata[HI_W-1:0]   = reload_q[CNT_W-1:BYTE_W];
      A_CLO:  bus_rdata             = count[BYTE_W-1:0];
      A_CHI:  bus_rdata[HI_W-1:0]   = hi_q;
      default: bus_rdata = '0;
    endcase
  end

  assign ctrl     = ctrl_q;
  assign reload   = reload_q;
  assign flag     = flag_q;
  assign hi_latch = hi_q;
endmodule

// File: rtl/wake_timer.sv
module wake_timer
  import wkt_pkg::*;
#(
  parameter int unsigned PRESC_W = 7,
  parameter int unsigned CNT_W   = 16
) (
  input  logic                  clk,
  input  logic                  por_rst_n,
  input  logic                  wdt_rst_n,
  input  logic                  osc_tick,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0]     bus_wdata,
  output logic [BYTE_W-1:0]     bus_rdata,
  output logic                  irq,
  output logic                  wake
);
  localparam int unsigned HI_W = CNT_W - BYTE_W;

  logic             timer_rst_n;
  ctrl_t            ctrl;
  logic             run_en, tick, step, preload, wrap, flag, flag_clr, lat_en;
  logic [CNT_W-1:0] count, reload, preload_val;
  logic [HI_W-1:0]  hi_latch;

  // Only the two timer-domain reset classes reach this block.
  assign timer_rst_n = por_rst_n & wdt_rst_n;
  assign run_en      = ctrl.run;

  wkt_tick_sel u_tick (
    .run      (run_en),
    .src_osc  (ctrl.src_osc),
    .osc_tick (osc_tick),
    .tick     (tick)
  );

  wkt_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk   (clk),
    .rst_n (timer_rst_n),
    .clear (preload),
    .tick  (tick),
    .step  (step)
  );

  wkt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (timer_rst_n),
    .preload     (preload),
    .preload_val (preload_val),
    .step        (step),
    .reload      (reload),
    .count       (count),
    .wrap        (wrap)
  );

  wkt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk         (clk),
    .rst_n       (timer_rst_n),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .count       (count),
    .wrap        (wrap),
    .ctrl        (ctrl),
    .reload      (reload),
    .preload     (preload),
    .preload_val (preload_val),
    .flag        (flag),
    .flag_clr    (flag_clr),
    .lat_en      (lat_en),
    .hi_latch    (hi_latch)
  );

  assign irq  = flag && ctrl.irq_en;
  assign wake = flag && ctrl.wake_en;
endmodule

// File: rtl/wkt_checker.sv
module wkt_checker #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned HI_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             step,
  input logic             preload,
  input logic             flag,
  input logic             flag_clr,
  input logic             lat_en,
  input logic             wake,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] reload,
  input logic [HI_W-1:0]  hi_latch
);
  a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (step && count != '0 && !preload) |=> (count == $past(count) - 1'b1));

  a_r2_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (step && count == '0 && !preload) |=> (count == $past(reload) && flag));

  a_r4_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !preload) |=> $stable(count));

  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag);

  a_r7_wake_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> flag);

  a_r8_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_en |=> $stable(hi_latch));
endmodule

bind wake_timer wkt_checker #(.CNT_W(CNT_W), .HI_W(CNT_W - 8)) u_chk (
  .clk      (clk),
  .rst_n    (timer_rst_n),
  .run      (run_en),
  .step     (step),
  .preload  (preload),
  .flag     (flag),
  .flag_clr (flag_clr),
  .lat_en   (lat_en),
  .wake     (wake),
  .count    (count),
  .reload   (reload),
  .hi_latch (hi_latch)
);

// File: tb/wake_timer_bench.sv
module wake_timer_bench;
  localparam int PW = 2;
  localparam int CW = 10;
  localparam int DIV = 1 << PW;

  logic       clk = 1'b0;
  logic       por_rst_n = 1'b0;
  logic       wdt_rst_n = 1'b1;
  logic       osc_tick = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq, wake;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  wake_timer #(.PRESC_W(PW), .CNT_W(CW)) u_wake_timer (
    .clk(clk), .por_rst_n(por_rst_n), .wdt_rst_n(wdt_rst_n), .osc_tick(osc_tick),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .wake(wake)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic do_write(input logic [2:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
  endtask

  task automatic peek(input logic [2:0] a, output int v);
    bus_rd = 1'b0; bus_addr = a;
    #1 v = int'(bus_rdata);
  endtask

  // Strobed low-byte read, then high byte one cycle later (one clock edge used).
  task automatic read_count(output int v);
    int lo;
    bus_rd = 1'b1; bus_addr = 3'd4;
    #1 lo = int'(bus_rdata);
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0; bus_addr = 3'd5;
    #1 v = (int'(bus_rdata) << 8) | lo;
  endtask

  task automatic setup(input int r, input logic [7:0] ctl);
    do_write(3'd0, 8'h00);
    do_write(3'd2, 8'(r));
    do_write(3'd3, 8'(r >> 8));
    do_write(3'd1, 8'h01);
    do_write(3'd0, ctl);
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v, t, first, ticks;
    int core_r[6] = '{0, 1, 2, 3, 7, 300};
    int osc_r[2] = '{1, 4};
    int samp[2];

    wait_cyc(3);
    por_rst_n = 1'b1;
    wait_cyc(1);

    // R9/R10: reset state
    peek(3'd0, v); check("R9 ctrl after por", v, 0);
    peek(3'd1, v); check("R9 flag after por", v, 0);
    peek(3'd2, v); check("R9 reload lo after por", v, 0);
    read_count(v); check("R9 count after por", v, 0);
    check("R7 irq after por", int'(irq), 0);

    // R1/R2: core tick, flag after (r+1)*DIV cycles
    foreach (core_r[i]) begin
      setup(core_r[i], 8'h05);
      first = -1;
      for (int k = 1; k <= DIV * (core_r[i] + 1) + 2; k++) begin
        @(negedge clk); #1;
        if (irq && first < 0) first = k;
      end
      check($sformatf("R1 R2 core period reload=%0d", core_r[i]), first, DIV * (core_r[i] + 1));
    end

    // R3: oscillator tick source
    foreach (osc_r[i]) begin
      setup(osc_r[i], 8'h07);
      ticks = 0; first = -1;
      for (int c = 0; c < 3000 && first < 0; c++) begin
        osc_tick = (c % 3 == 1);
        @(posedge clk);
        if (osc_tick) ticks++;
        @(negedge clk); #1;
        if (irq) first = ticks;
      end
      osc_tick = 1'b0;
      check($sformatf("R3 osc ticks to flag reload=%0d", osc_r[i]), first, DIV * (osc_r[i] + 1));
    end

    // R2/R8: live count across wraps, upper bits included
    setup(300, 8'h01);
    t = 0;
    for (int n = 0; n < 20; n++) begin
      wait_cyc(97); t += 97;
      read_count(v);
      check($sformatf("R2 R8 count at t=%0d", t), v, 300 - ((t / DIV) % 301));
      t += 1;
    end

    // R8: captured upper bits stay until the next strobed low read
    setup(300, 8'h01);
    read_count(v);
    check("R8 first read", v, 300);
    wait_cyc(200);
    peek(3'd5, v);
    check("R8 upper bits held stale", v, 1);
    read_count(v);
    check("R8 fresh read after strobe", v, 300 - (202 / DIV));

    // R5: reload written while running, then R4 stop
    setup(3, 8'h01);
    wait_cyc(2);
    do_write(3'd2, 8'd9);
    read_count(v); check("R5 running write does not preload", v, 3);
    wait_cyc(13);
    read_count(v); check("R5 new reload used at wrap", v, 9);
    do_write(3'd0, 8'h00);
    read_count(samp[0]); check("R4 count at stop", samp[0], 9);
    wait_cyc(40);
    read_count(samp[1]); check("R4 count held while stopped", samp[1], samp[0]);
    peek(3'd1, v); check("R2 flag set by wrap", v, 1);

    // R7: output gating by enables
    check("R7 irq gated off", int'(irq), 0);
    check("R7 wake gated off", int'(wake), 0);
    do_write(3'd0, 8'h08);
    check("R7 wake enabled", int'(wake), 1);
    check("R7 irq still gated", int'(irq), 0);
    do_write(3'd0, 8'h04);
    check("R7 irq enabled", int'(irq), 1);

    // R6: write-one-to-clear
    do_write(3'd1, 8'h00);
    peek(3'd1, v); check("R6 write 0 no effect", v, 1);
    do_write(3'd1, 8'h01);
    peek(3'd1, v); check("R6 write 1 clears", v, 0);
    check("R6 irq drops with flag", int'(irq), 0);

    // R5: preload while stopped
    do_write(3'd0, 8'h00);
    do_write(3'd2, 8'h55);
    read_count(v); check("R5 preload while stopped", v, 9'h055);
    do_write(3'd3, 8'h02);
    read_count(v); check("R5 preload upper bits", v, 10'h255);

    // R10: readback and unused addresses
    do_write(3'd0, 8'h0D);
    peek(3'd0, v); check("R10 ctrl readback", v, 8'h0D);
    peek(3'd2, v); check("R10 reload lo readback", v, 8'h55);
    peek(3'd3, v); check("R10 reload hi readback", v, 2);
    peek(3'd6, v); check("R10 unused addr 6", v, 0);
    peek(3'd7, v); check("R10 unused addr 7", v, 0);

    // R9: watchdog reset clears everything
    wait_cyc(30);
    wdt_rst_n = 1'b0;
    wait_cyc(2);
    wdt_rst_n = 1'b1;
    wait_cyc(1);
    peek(3'd0, v); check("R9 ctrl after wdt", v, 0);
    peek(3'd2, v); check("R9 reload lo after wdt", v, 0);
    peek(3'd3, v); check("R9 reload hi after wdt", v, 0);
    read_count(v); check("R9 count after wdt", v, 0);
    peek(3'd1, v); check("R9 flag after wdt", v, 0);

    // R1: prescaler full after reset, reload 0 gives flag after DIV ticks
    do_write(3'd0, 8'h05);
    first = -1;
    for (int k = 1; k <= DIV + 2; k++) begin
      @(negedge clk); #1;
      if (irq && first < 0) first = k;
    end
    check("R1 R9 prescaler full after wdt", first, DIV);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule